// File: doc/BRIEF.md
# Serial Command-Byte Register Port

This block lets a host reach a small register bank over a four-wire serial link. Each access opens with one 8-bit command byte, which is written to a command register that cannot be read back. The byte chooses read or write and names a 6-bit target address. A single data phase follows. Its length is 8, 16 or 24 bits, and the target address decides which. When the data phase ends, the port waits for a new command byte. Chip select can stay low across many accesses.

The port runs on a fast system clock and oversamples the serial clock, chip select and data input. The host should hold each serial clock level for at least three system clocks. Data is captured on rising serial edges and driven out on falling ones, most significant bit first. The bank sits outside the block and is reached through an address, a write-data bus, a one-cycle write strobe and a combinational read-data bus. If the host holds the data input high for a long enough run, the port returns to the command-wait state and sends a one-cycle reset pulse to the bank.

Top module: `serial_reg_port`

## Requirements
- R1: While `rst` is high and afterwards until a transfer starts, `sdo`, `bank_we` and `bank_rst` are 0, and the next 8 serial bits are taken as a command byte.
- R2: A command byte is sampled on rising serial-clock edges, MSB first. Bit 7 must be 0. Bit 6 selects read (1) or write (0). Bits 5..0 are the target address, and for per-channel registers the low 3 of these bits are the channel number 0..7.
- R3: The data phase length depends on the address: 24 bits for 0x08..0x0F, 16 bits for 0x10..0x17, and 8 bits for every other address (0x01 included). In a write strobe, bits of `bank_wdata` above that length are 0.
- R4: In a write, the data bits are captured MSB first. On the last bit, exactly one single-cycle `bank_we` pulse is issued, with `bank_addr` set to the target and `bank_wdata` holding the received value right-justified.
- R5: In a read, the low bits of `bank_rdata` for the target width are shifted out on `sdo`, MSB first. Each bit changes after a falling serial edge, so the first bit is valid before the first data rising edge. Unmapped addresses, including command address 0x00, read as all zeros.
- R6: Only 0x01 and 0x08..0x17 are mapped. A write to any other address completes its data phase but gives no `bank_we`.
- R7: A command byte with bit 7 set is ignored. The port keeps waiting, and the next 8 bits are treated as a command byte.
- R8: After a data phase completes, the next 8 bits are a command byte, and chip select does not need to toggle.
- R9: Raising `cs_n` in the middle of a byte abandons the transfer without a write strobe and without `bank_rst`. After `cs_n` goes low again, a new command byte is expected.
- R10: When `sdi` is 1 on 32 consecutive rising serial edges with `cs_n` low, one single-cycle `bank_rst` pulse is issued and the port returns to command wait. The run is counted across command, write and read phases. A 0 bit or a high `cs_n` clears the run, and a longer run does not pulse again.
- R11: `sdo` is 0 while `cs_n` is high and outside read data phases.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| sclk | input | 1 | Serial clock from the host |
| sdi | input | 1 | Serial data from the host |
| sdo | output | 1 | Serial data to the host |
| bank_addr | output | 6 | Target register address |
| bank_wdata | output | 24 | Write data, right-justified |
| bank_we | output | 1 | One-cycle write strobe |
| bank_rdata | input | 24 | Combinational read data for `bank_addr` |
| bank_rst | output | 1 | One-cycle reset pulse to the bank |

## Verification
A bit counter that is off by one puts every later command out of frame. This shows up at the ports within the next access: a strobe goes to the wrong address or carries shifted data, or read bits come out displaced by one position. A bad width lookup gives a strobe one byte early or late, or leaves stale upper bits on `bank_wdata`. A run detector that does not clear, or that counts across chip-select gaps, shows up as an extra or missing `bank_rst` pulse within 32 serial bits. A stale phase state after chip select goes high shows up as a lingering `sdo` level or a missing strobe on the next access.

// File: rtl/srp_pkg.sv
package srp_pkg;

    localparam int DATA_W = 24;
    localparam int ADDR_W = 6;
    localparam int CMD_W  = 8;
    localparam int CNT_W  = $clog2(DATA_W + 1);

    typedef enum logic [1:0] {
        ST_CMD,
        ST_LOAD,
        ST_DATA
    } srp_state_e;

    // command byte layout: the framing of the byte is behaviour
    typedef struct packed {
        logic              bad;   // must be 0
        logic              rd;    // 1: read, 0: write
        logic [ADDR_W-1:0] addr;  // target address
    } srp_cmd_t;

    // data phase length for an address
    function automatic logic [CNT_W-1:0] width_of(input logic [ADDR_W-1:0] a);
        if (a[ADDR_W-1:3] == 3'b001)
            return CNT_W'(24);
        else if (a[ADDR_W-1:3] == 3'b010)
            return CNT_W'(16);
        else
            return CNT_W'(8);
    endfunction

    function automatic logic is_mapped(input logic [ADDR_W-1:0] a);
        return (a == ADDR_W'(1)) || (a[ADDR_W-1:3] == 3'b001) || (a[ADDR_W-1:3] == 3'b010);
    endfunction

    function automatic logic [DATA_W-1:0] low_mask(input logic [CNT_W-1:0] w);
        return {DATA_W{1'b1}} >> (DATA_W - int'(w));
    endfunction

    // move the low w bits to the top of the shifter
    function automatic logic [DATA_W-1:0] align_top(input logic [DATA_W-1:0] d,
                                                    input logic [CNT_W-1:0]  w);
        return (d & low_mask(w)) << (DATA_W - int'(w));
    endfunction

endpackage

// File: rtl/srp_sample.sv
module srp_sample (
    input  logic clk,
    input  logic rst,
    input  logic sclk,
    input  logic cs_n,
    input  logic sdi,
    output logic rise,
    output logic fall,
    output logic sel,
    output logic sdi_s
);
    logic [1:0] sclk_h;
    logic       sel_q;
    logic       sdi_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            sclk_h <= '0;
            sel_q  <= 1'b0;
            sdi_q  <= 1'b0;
        end else begin
            sclk_h <= {sclk_h[0], sclk};
            sel_q  <= ~cs_n;
            sdi_q  <= sdi;
        end
    end

    assign rise  = sel_q &  sclk_h[0] & ~sclk_h[1];
    assign fall  = sel_q & ~sclk_h[0] &  sclk_h[1];
    assign sel   = sel_q;
    assign sdi_s = sdi_q;
endmodule

// File: rtl/srp_ones_watch.sv
module srp_ones_watch #(
    parameter int RUN_LEN = 32
) (
    input  logic clk,
    input  logic rst,
    input  logic rise,
    input  logic sel,
    input  logic sdi_s,
    output logic fire,
    output logic pulse
);
    localparam int RUN_W = $clog2(RUN_LEN + 1);

    logic [RUN_W-1:0] run_q;

    assign fire = rise & sdi_s & (run_q == RUN_W'(RUN_LEN - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            run_q <= '0;
            pulse <= 1'b0;
        end else begin
            pulse <= fire;
            if (!sel)
                run_q <= '0;
            else if (rise) begin
                if (!sdi_s)
                    run_q <= '0;
                else if (run_q != RUN_W'(RUN_LEN))
                    run_q <= run_q + RUN_W'(1);
            end
        end
    end
endmodule

// File: rtl/srp_engine.sv
module srp_engine
    import srp_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              soft_rst,
    input  logic              rise,
    input  logic              fall,
    input  logic              sel,
    input  logic              sdi_s,
    input  logic [DATA_W-1:0] bank_rdata,
    output logic              sdo,
    output logic [ADDR_W-1:0] bank_addr,
    output logic [DATA_W-1:0] bank_wdata,
    output logic              bank_we
);
    srp_state_e        state;
    logic [DATA_W-1:0] shreg;
    logic [DATA_W-1:0] shift_in;
    logic [CNT_W-1:0]  bitcnt;
    logic [CNT_W-1:0]  width_q;
    logic              rd_q;
    logic [ADDR_W-1:0] addr_q;
    logic              sdo_q;
    logic              we_q;
    logic [DATA_W-1:0] wdata_q;
    srp_cmd_t          cmd_next;

    assign shift_in = {shreg[DATA_W-2:0], sdi_s};
    assign cmd_next = srp_cmd_t'(shift_in[CMD_W-1:0]);

    always_ff @(posedge clk) begin
        if (rst || soft_rst) begin
            state   <= ST_CMD;
            bitcnt  <= '0;
            shreg   <= '0;
            width_q <= CNT_W'(CMD_W);
            rd_q    <= 1'b0;
            addr_q  <= '0;
            sdo_q   <= 1'b0;
            we_q    <= 1'b0;
            wdata_q <= '0;
        end else if (!sel) begin
            state  <= ST_CMD;
            bitcnt <= '0;
            sdo_q  <= 1'b0;
            we_q   <= 1'b0;
        end else begin
            we_q <= 1'b0;
            case (state)
                ST_CMD: begin
                    if (fall)
                        sdo_q <= 1'b0;
                    if (rise) begin
                        shreg <= shift_in;
                        if (bitcnt == CNT_W'(CMD_W - 1)) begin
                            bitcnt <= '0;
                            if (!cmd_next.bad) begin
                                addr_q  <= cmd_next.addr;
                                rd_q    <= cmd_next.rd;
                                width_q <= width_of(cmd_next.addr);
                                state   <= cmd_next.rd ? ST_LOAD : ST_DATA;
                            end
                        end else begin
                            bitcnt <= bitcnt + CNT_W'(1);
                        end
                    end
                end
                ST_LOAD: begin
                    shreg <= is_mapped(addr_q) ? align_top(bank_rdata, width_q) : '0;
                    state <= ST_DATA;
                end
                ST_DATA: begin
                    if (rd_q && fall) begin
                        sdo_q <= shreg[DATA_W-1];
                        shreg <= shreg << 1;
                    end
                    if (rise) begin
                        if (!rd_q)
                            shreg <= shift_in;
                        if (bitcnt == width_q - CNT_W'(1)) begin
                            bitcnt <= '0;
                            state  <= ST_CMD;
                            if (!rd_q) begin
                                we_q    <= is_mapped(addr_q);
                                wdata_q <= shift_in & low_mask(width_q);
                            end
                        end else begin
                            bitcnt <= bitcnt + CNT_W'(1);
                        end
                    end
                end
                default: state <= ST_CMD;
            endcase
        end
    end

    assign sdo        = sdo_q;
    assign bank_addr  = addr_q;
    assign bank_wdata = wdata_q;
    assign bank_we    = we_q;
endmodule

// File: rtl/serial_reg_port.sv
module serial_reg_port
    import srp_pkg::*;
#(
    parameter int RUN_LEN = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cs_n,
    input  logic              sclk,
    input  logic              sdi,
    output logic              sdo,
    output logic [ADDR_W-1:0] bank_addr,
    output logic [DATA_W-1:0] bank_wdata,
    output logic              bank_we,
    input  logic [DATA_W-1:0] bank_rdata,
    output logic              bank_rst
);
    logic rise;
    logic fall;
    logic sel;
    logic sdi_s;
    logic fire;

    srp_sample u_sample (
        .clk   (clk),
        .rst   (rst),
        .sclk  (sclk),
        .cs_n  (cs_n),
        .sdi   (sdi),
        .rise  (rise),
        .fall  (fall),
        .sel   (sel),
        .sdi_s (sdi_s)
    );

    srp_ones_watch #(.RUN_LEN(RUN_LEN)) u_ones (
        .clk   (clk),
        .rst   (rst),
        .rise  (rise),
        .sel   (sel),
        .sdi_s (sdi_s),
        .fire  (fire),
        .pulse (bank_rst)
    );

    srp_engine u_engine (
        .clk        (clk),
        .rst        (rst),
        .soft_rst   (fire),
        .rise       (rise),
        .fall       (fall),
        .sel        (sel),
        .sdi_s      (sdi_s),
        .bank_rdata (bank_rdata),
        .sdo        (sdo),
        .bank_addr  (bank_addr),
        .bank_wdata (bank_wdata),
        .bank_we    (bank_we)
    );
endmodule

// File: rtl/srp_checker.sv
module srp_checker
    import srp_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              cs_n,
    input logic              sdo,
    input logic [ADDR_W-1:0] bank_addr,
    input logic [DATA_W-1:0] bank_wdata,
    input logic              bank_we,
    input logic              bank_rst
);
    logic [1:0] warm;

    always_ff @(posedge clk) begin
        if (rst)
            warm <= '0;
        else if (warm != 2'd3)
            warm <= warm + 2'd1;
    end

    // R4: the write strobe lasts a single cycle
    assert_we_single_R4: assert property (@(posedge clk) disable iff (rst)
        bank_we |=> !bank_we);

    // R6: strobes only reach mapped addresses
    assert_we_mapped_R6: assert property (@(posedge clk) disable iff (rst)
        bank_we |-> is_mapped(bank_addr));

    // R3: no bits above the access width in the write data
    assert_wdata_width_R3: assert property (@(posedge clk) disable iff (rst)
        bank_we |-> ((bank_wdata & ~low_mask(width_of(bank_addr))) == '0));

    // R10: the run reset is a lone pulse and never coincides with a strobe
    assert_rst_single_R10: assert property (@(posedge clk) disable iff (rst)
        bank_rst |=> !bank_rst);

    assert_rst_no_we_R10: assert property (@(posedge clk) disable iff (rst)
        bank_rst |-> !bank_we);

    // R11: output quiet once chip select has been high for two cycles
    assert_sdo_quiet_R11: assert property (@(posedge clk) disable iff (rst)
        (warm == 2'd3 && $past(cs_n) && $past(cs_n, 2)) |-> !sdo);
endmodule

bind serial_reg_port srp_checker u_chk (
    .clk        (clk),
    .rst        (rst),
    .cs_n       (cs_n),
    .sdo        (sdo),
    .bank_addr  (bank_addr),
    .bank_wdata (bank_wdata),
    .bank_we    (bank_we),
    .bank_rst   (bank_rst)
);

// File: tb/serial_reg_port_tb.sv
module serial_reg_port_tb;
    localparam int CLK_PERIOD = 10;
    localparam int HALF       = 4;
    localparam int NVEC       = 10;

    // {rd, addr[5:0], data[23:0]}
    localparam logic [30:0] VECS [0:NVEC-1] = '{
        {1'b0, 6'h01, 24'h0000C3},
        {1'b0, 6'h0A, 24'hABCDEF},
        {1'b0, 6'h13, 24'h001234},
        {1'b0, 6'h20, 24'h000055},
        {1'b1, 6'h01, 24'h000000},
        {1'b1, 6'h0C, 24'h000000},
        {1'b1, 6'h15, 24'h000000},
        {1'b1, 6'h00, 24'h000000},
        {1'b1, 6'h30, 24'h000000},
        {1'b0, 6'h17, 24'h00BEEF}
    };

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cs_n = 1'b1;
    logic        sclk = 1'b0;
    logic        sdi = 1'b0;
    logic        sdo;
    logic [5:0]  bank_addr;
    logic [23:0] bank_wdata;
    logic        bank_we;
    logic [23:0] bank_rdata;
    logic        bank_rst;

    int total = 0;
    int bad   = 0;
    int we_cnt = 0;
    int rst_cnt = 0;
    logic [5:0]  we_addr = '0;
    logic [23:0] we_data = '0;
    logic        done = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [23:0] pat(input logic [5:0] a);
        return {2'b10, a, 2'b01, ~a, 2'b11, a};
    endfunction

    function automatic int bw(input logic [5:0] a);
        if (a >= 6'h08 && a <= 6'h0F) return 24;
        if (a >= 6'h10 && a <= 6'h17) return 16;
        return 8;
    endfunction

    function automatic logic bmap(input logic [5:0] a);
        return (a == 6'h01) || (a >= 6'h08 && a <= 6'h17);
    endfunction

    assign bank_rdata = pat(bank_addr);

    serial_reg_port u_dut (
        .clk        (clk),
        .rst        (rst),
        .cs_n       (cs_n),
        .sclk       (sclk),
        .sdi        (sdi),
        .sdo        (sdo),
        .bank_addr  (bank_addr),
        .bank_wdata (bank_wdata),
        .bank_we    (bank_we),
        .bank_rdata (bank_rdata),
        .bank_rst   (bank_rst)
    );

    always @(negedge clk) begin
        if (!rst) begin
            if (bank_we) begin
                we_cnt  = we_cnt + 1;
                we_addr = bank_addr;
                we_data = bank_wdata;
            end
            if (bank_rst) rst_cnt = rst_cnt + 1;
        end
    end

    task automatic check(input string req, input logic [23:0] act, input logic [23:0] exp);
        total = total + 1;
        if (act !== exp) begin
            bad = bad + 1;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic xfer_bit(input logic b, output logic got);
        sdi = b;
        repeat (HALF) @(negedge clk);
        got = sdo;
        sclk = 1'b1;
        repeat (HALF) @(negedge clk);
        sclk = 1'b0;
    endtask

    task automatic send_bits(input logic [23:0] v, input int n);
        logic g;
        for (int i = n - 1; i >= 0; i--) xfer_bit(v[i], g);
    endtask

    task automatic read_bits(input int n, input logic fill, output logic [23:0] r);
        logic g;
        r = '0;
        for (int i = 0; i < n; i++) begin
            xfer_bit(fill, g);
            r = {r[22:0], g};
        end
    endtask

    task automatic settle();
        repeat (HALF) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            total = total + 1;
            bad   = bad + 1;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [23:0] r;
        int pre;
        int pre_rst;

        // R1: reset state
        repeat (5) @(negedge clk);
        rst = 1'b0;
        repeat (3) @(negedge clk);
        check("R1 sdo", 24'(sdo), 24'h0);
        check("R1 we", 24'(we_cnt), 24'h0);
        check("R1 bank_rst", 24'(rst_cnt), 24'h0);
        cs_n = 1'b0;
        repeat (3) @(negedge clk);

        // R2 R8: back-to-back accesses with chip select held low
        for (int k = 0; k < NVEC; k++) begin
            logic        rd;
            logic [5:0]  a;
            logic [23:0] d;
            int          w;
            rd = VECS[k][30];
            a  = VECS[k][29:24];
            d  = VECS[k][23:0];
            w  = bw(a);
            pre = we_cnt;
            send_bits({16'h0, 1'b0, rd, a}, 8);
            if (rd) begin
                read_bits(w, 1'b0, r);
                check("R5 R3 read", r, bmap(a) ? (pat(a) & (24'hFFFFFF >> (24 - w))) : 24'h0);
            end else begin
                send_bits(d, w);
                settle();
                if (bmap(a)) begin
                    check("R4 R8 strobe count", 24'(we_cnt - pre), 24'd1);
                    check("R4 addr", 24'(we_addr), 24'(a));
                    check("R3 R4 data", we_data, d);
                end else begin
                    check("R6 no strobe", 24'(we_cnt - pre), 24'd0);
                end
            end
        end

        // R7: invalid command byte ignored, next byte is a command
        pre = we_cnt;
        send_bits(24'h81, 8);
        send_bits(24'h01, 8);
        send_bits(24'h3C, 8);
        settle();
        check("R7 strobe count", 24'(we_cnt - pre), 24'd1);
        check("R7 data", we_data, 24'h3C);

        // R9: abandon a write mid-phase
        pre = we_cnt;
        send_bits(24'h0A, 8);
        send_bits(24'h2A5, 10);
        cs_n = 1'b1;
        settle();
        check("R9 no strobe", 24'(we_cnt - pre), 24'd0);
        check("R9 no bank_rst", 24'(rst_cnt), 24'd0);
        cs_n = 1'b0;
        settle();
        send_bits(24'h01, 8);
        send_bits(24'h77, 8);
        settle();
        check("R9 recover count", 24'(we_cnt - pre), 24'd1);
        check("R9 recover data", we_data, 24'h77);

        // R5 R11: first read bit present early, cleared on deselect
        send_bits(24'h48, 8);
        settle();
        check("R5 first bit", 24'(sdo), 24'd1);
        cs_n = 1'b1;
        settle();
        check("R11 sdo idle", 24'(sdo), 24'd0);
        cs_n = 1'b0;
        settle();

        // R10: run of ones spanning a read and the following command wait
        pre = we_cnt;
        pre_rst = rst_cnt;
        send_bits(24'h4F, 8);
        read_bits(24, 1'b1, r);
        check("R10 R5 read under ones", r, pat(6'h0F));
        send_bits(24'h7, 3);
        settle();
        check("R10 no pulse at 31", 24'(rst_cnt - pre_rst), 24'd0);
        send_bits(24'h1, 1);
        settle();
        check("R10 pulse at 32", 24'(rst_cnt - pre_rst), 24'd1);
        send_bits(24'hFF, 8);
        settle();
        check("R10 single pulse", 24'(rst_cnt - pre_rst), 24'd1);
        check("R10 no strobe", 24'(we_cnt - pre), 24'd0);
        send_bits(24'h01, 8);
        send_bits(24'h5A, 8);
        settle();
        check("R10 R8 resume", we_data, 24'h5A);
        check("R10 resume count", 24'(we_cnt - pre), 24'd1);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule